// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general register storage of a processor core with several privilege modes. It holds sixteen 32-bit registers as seen by software, but some of them exist in more than one physical copy. The stack register (13), the link register (14) and a saved-status word are replicated once per bank. Registers 8 to 12 have a second copy that is used only in the fast-interrupt mode. Registers 0 to 7 and register 15 are shared by every mode. The block keeps the current mode itself. A mode-change request swaps the visible copies on the next clock edge.

Software-visible access is through two combinational read ports and one write port, all addressed by register number. A separate port reads and writes the saved-status word of the current bank. An illegal target mode encoding is refused and reported on an error output. All writes and all read-port decoding use the bank of the mode that is current at the clock edge. A write in the same cycle as a mode switch therefore lands in the outgoing bank.

Top module: `mrf_banked_regfile`

## Requirements
- R1: Mode encodings are user 0x10, fast interrupt 0x11, interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B and system 0x1F. Each legal mode selects one of six banks: user/system 0, supervisor 1, abort 2, undefined 3, interrupt 4, fast interrupt 5. `cur_mode` always holds a legal encoding.
- R2: Registers 13 and 14 each have one copy per bank. A value written in one mode is seen again after leaving that mode and returning, and it is not seen from a mode in another bank.
- R3: User and system modes share bank 0, so a value written in either is visible in the other.
- R4: Registers 8 to 12 have a fast copy that is visible only in fast-interrupt mode. All other modes share the other copy.
- R5: Registers 0 to 7 and register 15 have one copy that is visible in every mode.
- R6: The saved-status port reads and writes the copy belonging to the current bank, one copy per bank.
- R7: A request whose target equals the current mode changes no register, status word or mode, and raises no error.
- R8: A request with an encoding outside the R1 list sets `mode_err` for exactly the following cycle and leaves the mode and the visible registers unchanged. `mode_err` is never set without such a request.
- R9: A register write or a status write in the same cycle as a mode switch goes to the bank of the old mode.
- R10: A synchronous active-low reset clears every copy of every register and status word to zero, sets the mode to supervisor (0x13) and clears `mode_err`.
- R11: Reads are combinational. A legal request updates `cur_mode` at the next rising clock edge, and the new bank's copies are visible from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_addr | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_addr | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register write number |
| wr_data | input | 32 | Register write data |
| sts_wr_en | input | 1 | Saved-status write enable |
| sts_wr_data | input | 32 | Saved-status write data |
| sts_rd_data | output | 32 | Saved status of the current bank |
| mode_req | input | 1 | Mode-change request |
| mode_tgt | input | 5 | Target mode encoding |
| cur_mode | output | 5 | Current mode encoding |
| mode_err | output | 1 | Illegal target mode reported in the previous cycle |

## Verification
The registers are first filled with distinct per-mode values in all six banks. Every bank is then revisited, which distinguishes a correct bank map from one where two modes alias or where a copy is not preserved across a swap. Separate patterns write the middle registers in user mode and in fast-interrupt mode and read them from a third mode, which separates the two copies of 8 to 12 from the shared low registers and register 15. Further cases cover a switch to the current mode, illegal encodings, and a write combined with a switch in the same cycle. These show whether the write lands in the outgoing bank and whether a refused request disturbs any state.

// File: rtl/mrf_pkg.sv
// Package: shared types, mode encodings and the mode-to-bank map for the
// banked register file. Assumes a 5-bit mode field and six banks.
package mrf_pkg;

    localparam int MODE_W    = 5;
    localparam int NBANK     = 6;
    localparam int BANK_W    = $clog2(NBANK);
    localparam int MID_FIRST = 8;                      // first fast-banked register
    localparam int NMID      = 5;                      // count of fast-banked registers
    localparam int NREG      = MID_FIRST + NMID + 3;   // plus stack, link, counter
    localparam int REG_AW    = $clog2(NREG);

    typedef logic [MODE_W-1:0] mode_t;
    typedef logic [BANK_W-1:0] bank_t;

    localparam mode_t MODE_USR = 5'h10;
    localparam mode_t MODE_FIQ = 5'h11;
    localparam mode_t MODE_IRQ = 5'h12;
    localparam mode_t MODE_SVC = 5'h13;
    localparam mode_t MODE_ABT = 5'h17;
    localparam mode_t MODE_UND = 5'h1B;
    localparam mode_t MODE_SYS = 5'h1F;

    localparam bank_t BANK_FIQ = 3'd5;

    typedef struct packed {
        logic  ok;
        bank_t bank;
    } mode_dec_t;

    // Map a mode encoding to its bank; ok is low for an illegal encoding.
    function automatic mode_dec_t decode_mode(input mode_t m);
        mode_dec_t d;
        d.ok   = 1'b1;
        d.bank = '0;
        case (m)
            MODE_USR, MODE_SYS: d.bank = 3'd0;
            MODE_SVC:           d.bank = 3'd1;
            MODE_ABT:           d.bank = 3'd2;
            MODE_UND:           d.bank = 3'd3;
            MODE_IRQ:           d.bank = 3'd4;
            MODE_FIQ:           d.bank = BANK_FIQ;
            default:            d.ok   = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mrf_mode_decode.sv
// Module: combinational mode decoder. Turns a target mode encoding into a
// legality flag and a bank index. Assumes the map in mrf_pkg.
module mrf_mode_decode
    import mrf_pkg::*;
(
    input  mode_t mode,
    output logic  ok,
    output bank_t bank
);

    mode_dec_t dec;

    // Decode through the shared package map.
    always_comb begin
        dec  = decode_mode(mode);
        ok   = dec.ok;
        bank = dec.bank;
    end

endmodule

// File: rtl/mrf_mode_ctrl.sv
// Module: current-mode register. Accepts a switch request when the target is
// legal, flags an illegal target for one cycle, and keeps the bank index of
// the current mode in a register so storage selects it with no decode delay.
// Assumes the target has already been decoded by mrf_mode_decode.
module mrf_mode_ctrl
    import mrf_pkg::*;
#(
    parameter mode_t RESET_MODE = MODE_SVC
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req,
    input  mode_t tgt,
    input  logic  tgt_ok,
    input  bank_t tgt_bank,
    output mode_t cur_mode,
    output bank_t cur_bank,
    output logic  err
);

    localparam mode_dec_t RST_DEC = decode_mode(RESET_MODE);

    // Update the mode and bank on a legal request that changes the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_mode <= RESET_MODE;
            cur_bank <= RST_DEC.bank;
        end else if (req && tgt_ok && (tgt != cur_mode)) begin
            cur_mode <= tgt;
            cur_bank <= tgt_bank;
        end
    end

    // Report an illegal target for the cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else begin
            err <= req && !tgt_ok;
        end
    end

endmodule

// File: rtl/mrf_reg_store.sv
// Module: physical register storage. Every banked copy is a separate
// register. The visible copy is chosen by the current bank index, so a
// mode change moves no data. Writes use the bank current at the edge.
// Assumes cur_bank always holds a legal bank index.
module mrf_reg_store
    import mrf_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NRD  = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  bank_t                            cur_bank,
    input  logic                             wr_en,
    input  logic [REG_AW-1:0]                wr_addr,
    input  logic [XLEN-1:0]                  wr_data,
    input  logic                             sts_wr_en,
    input  logic [XLEN-1:0]                  sts_wr_data,
    input  logic [NRD-1:0][REG_AW-1:0]       rd_addr,
    output logic [NRD-1:0][XLEN-1:0]         rd_data,
    output logic [XLEN-1:0]                  sts_rd_data
);

    localparam int NLOW   = MID_FIRST;
    localparam int LOW_W  = $clog2(NLOW);
    localparam int MID_W  = $clog2(NMID);
    localparam int SP_IDX = MID_FIRST + NMID;
    localparam int LR_IDX = SP_IDX + 1;
    localparam int PC_IDX = LR_IDX + 1;
    localparam int NSET   = 2;   // shared and fast copies of the middle registers

    logic [XLEN-1:0] low_vec [NLOW];
    logic [XLEN-1:0] mid_vec [NSET][NMID];
    logic [XLEN-1:0] sp_vec  [NBANK];
    logic [XLEN-1:0] lr_vec  [NBANK];
    logic [XLEN-1:0] sts_vec [NBANK];
    logic [XLEN-1:0] pc_q;
    logic            fast_sel;

    assign fast_sel = (cur_bank == BANK_FIQ);

    // Registers shared by every mode below the middle range.
    for (genvar i = 0; i < NLOW; i++) begin : g_low
        logic [XLEN-1:0] q;
        // Hold one shared low register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && (wr_addr == REG_AW'(i))) begin
                q <= wr_data;
            end
        end
        assign low_vec[i] = q;
    end

    // Middle registers: set 0 for all other modes, set 1 for the fast mode.
    for (genvar s = 0; s < NSET; s++) begin : g_set
        for (genvar i = 0; i < NMID; i++) begin : g_mid
            logic [XLEN-1:0] q;
            // Hold one copy of one middle register.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en && (wr_addr == REG_AW'(MID_FIRST + i))
                             && (fast_sel == (s == 1))) begin
                    q <= wr_data;
                end
            end
            assign mid_vec[s][i] = q;
        end
    end

    // Stack, link and saved status, one copy per bank.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [XLEN-1:0] sp_q;
        logic [XLEN-1:0] lr_q;
        logic [XLEN-1:0] sts_q;
        logic            here;
        assign here = (cur_bank == bank_t'(b));
        // Hold this bank's stack register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sp_q <= '0;
            end else if (wr_en && here && (wr_addr == REG_AW'(SP_IDX))) begin
                sp_q <= wr_data;
            end
        end
        // Hold this bank's link register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lr_q <= '0;
            end else if (wr_en && here && (wr_addr == REG_AW'(LR_IDX))) begin
                lr_q <= wr_data;
            end
        end
        // Hold this bank's saved status.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sts_q <= '0;
            end else if (sts_wr_en && here) begin
                sts_q <= sts_wr_data;
            end
        end
        assign sp_vec[b]  = sp_q;
        assign lr_vec[b]  = lr_q;
        assign sts_vec[b] = sts_q;
    end

    // Program counter slot, shared by every mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (wr_en && (wr_addr == REG_AW'(PC_IDX))) begin
            pc_q <= wr_data;
        end
    end

    // Select the visible copy for each read port.
    always_comb begin
        for (int p = 0; p < NRD; p++) begin
            logic [REG_AW-1:0] a;
            logic [REG_AW-1:0] off;
            a   = rd_addr[p];
            off = a - REG_AW'(MID_FIRST);
            if (a < REG_AW'(MID_FIRST)) begin
                rd_data[p] = low_vec[a[LOW_W-1:0]];
            end else if (a < REG_AW'(SP_IDX)) begin
                rd_data[p] = mid_vec[fast_sel][off[MID_W-1:0]];
            end else if (a == REG_AW'(SP_IDX)) begin
                rd_data[p] = sp_vec[cur_bank];
            end else if (a == REG_AW'(LR_IDX)) begin
                rd_data[p] = lr_vec[cur_bank];
            end else begin
                rd_data[p] = pc_q;
            end
        end
    end

    // Expose the current bank's saved status.
    assign sts_rd_data = sts_vec[cur_bank];

endmodule

// File: rtl/mrf_banked_regfile.sv
// Module: top of the mode-banked register file. Joins the target decoder,
// the mode register and the storage. Assumes two read ports and one write
// port. Mode changes take effect at the next clock edge.
module mrf_banked_regfile
    import mrf_pkg::*;
#(
    parameter int    XLEN       = 32,
    parameter mode_t RESET_MODE = MODE_SVC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_a_addr,
    output logic [XLEN-1:0]   rd_a_data,
    input  logic [3:0]        rd_b_addr,
    output logic [XLEN-1:0]   rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [XLEN-1:0]   wr_data,
    input  logic              sts_wr_en,
    input  logic [XLEN-1:0]   sts_wr_data,
    output logic [XLEN-1:0]   sts_rd_data,
    input  logic              mode_req,
    input  logic [4:0]        mode_tgt,
    output logic [4:0]        cur_mode,
    output logic              mode_err
);

    localparam int NRD = 2;

    logic                        tgt_ok;
    bank_t                       tgt_bank;
    bank_t                       cur_bank;
    logic [NRD-1:0][REG_AW-1:0]  rd_addr;
    logic [NRD-1:0][XLEN-1:0]    rd_data;

    assign rd_addr[0] = rd_a_addr;
    assign rd_addr[1] = rd_b_addr;
    assign rd_a_data  = rd_data[0];
    assign rd_b_data  = rd_data[1];

    mrf_mode_decode u_dec (
        .mode (mode_tgt),
        .ok   (tgt_ok),
        .bank (tgt_bank)
    );

    mrf_mode_ctrl #(.RESET_MODE(RESET_MODE)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (mode_req),
        .tgt      (mode_tgt),
        .tgt_ok   (tgt_ok),
        .tgt_bank (tgt_bank),
        .cur_mode (cur_mode),
        .cur_bank (cur_bank),
        .err      (mode_err)
    );

    mrf_reg_store #(.XLEN(XLEN), .NRD(NRD)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .cur_bank    (cur_bank),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .sts_wr_en   (sts_wr_en),
        .sts_wr_data (sts_wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .sts_rd_data (sts_rd_data)
    );

endmodule

// File: rtl/mrf_banked_regfile_chk.sv
// Checker: protocol properties of the mode register and the error flag,
// bound to the top module.
module mrf_banked_regfile_chk
    import mrf_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mode_req,
    input logic [4:0]      mode_tgt,
    input logic [4:0]      cur_mode,
    input logic            mode_err,
    input logic            wr_en,
    input logic            sts_wr_en,
    input logic [XLEN-1:0] sts_rd_data
);

    logic tgt_legal;
    logic cur_legal;
    assign tgt_legal = decode_mode(mode_tgt).ok;
    assign cur_legal = decode_mode(cur_mode).ok;

    assert_legal_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cur_legal);

    assert_same_mode_keeps_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_req && (mode_tgt == cur_mode) && !wr_en && !sts_wr_en) |=> $stable(sts_rd_data));

    assert_bad_mode_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_req && !tgt_legal) |=> mode_err);

    assert_bad_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_req && !tgt_legal) |=> $stable(cur_mode));

    assert_no_spurious_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_req |=> !mode_err);

    assert_switch_next_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_req && tgt_legal) |=> (cur_mode == $past(mode_tgt)));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_req |=> $stable(cur_mode));

endmodule

bind mrf_banked_regfile mrf_banked_regfile_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_req    (mode_req),
    .mode_tgt    (mode_tgt),
    .cur_mode    (cur_mode),
    .mode_err    (mode_err),
    .wr_en       (wr_en),
    .sts_wr_en   (sts_wr_en),
    .sts_rd_data (sts_rd_data)
);

// File: tb/tb_mrf_banked_regfile.sv
`timescale 1ns/1ps
module tb_mrf_banked_regfile;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  rd_a_addr, rd_b_addr, wr_addr;
    logic [31:0] rd_a_data, rd_b_data, wr_data, sts_wr_data, sts_rd_data;
    logic        wr_en, sts_wr_en, mode_req, mode_err;
    logic [4:0]  mode_tgt, cur_mode;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] exp_sp  [6];
    logic [31:0] exp_lr  [6];
    logic [31:0] exp_sts [6];

    localparam logic [4:0] M_USR = 5'h10, M_FIQ = 5'h11, M_IRQ = 5'h12,
                           M_SVC = 5'h13, M_ABT = 5'h17, M_UND = 5'h1B,
                           M_SYS = 5'h1F;

    always #10 clk = ~clk;   // 50 MHz

    mrf_banked_regfile dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data), .sts_rd_data(sts_rd_data),
        .mode_req(mode_req), .mode_tgt(mode_tgt),
        .cur_mode(cur_mode), .mode_err(mode_err)
    );

    // Bank map from R1.
    function automatic int bank_of(input logic [4:0] m);
        case (m)
            M_USR, M_SYS: return 0;
            M_SVC:        return 1;
            M_ABT:        return 2;
            M_UND:        return 3;
            M_IRQ:        return 4;
            default:      return 5;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #5;
    endtask

    task automatic read_a(input logic [3:0] a, output logic [31:0] d);
        rd_a_addr = a; #1; d = rd_a_data;
    endtask

    task automatic read_b(input logic [3:0] a, output logic [31:0] d);
        rd_b_addr = a; #1; d = rd_b_data;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic wr_sts(input logic [31:0] d);
        sts_wr_en = 1'b1; sts_wr_data = d;
        cyc();
        sts_wr_en = 1'b0;
    endtask

    task automatic sw(input logic [4:0] m);
        mode_req = 1'b1; mode_tgt = m;
        cyc();
        mode_req = 1'b0;
    endtask

    // R10: everything zero, supervisor mode, no error after reset.
    task automatic t_reset();
        logic [31:0] d;
        rst_n = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        check("R10 mode after reset", {27'd0, cur_mode}, {27'd0, M_SVC});
        check("R10 err after reset", {31'd0, mode_err}, 32'd0);
        check("R10 status after reset", sts_rd_data, 32'd0);
        for (int r = 0; r < 16; r++) begin
            read_a(4'(r), d);
            check($sformatf("R10 reg %0d after reset", r), d, 32'd0);
        end
    endtask

    // R5: low registers and register 15 visible from every mode.
    task automatic t_common();
        logic [31:0] d;
        for (int r = 0; r < 8; r++) wr(4'(r), 32'h1000_0000 + r);
        wr(4'd15, 32'h0000_0F00);
        sw(M_FIQ);
        for (int r = 0; r < 8; r++) begin
            read_b(4'(r), d);
            check($sformatf("R5 reg %0d in fast mode", r), d, 32'h1000_0000 + r);
        end
        read_b(4'd15, d);
        check("R5 reg 15 in fast mode", d, 32'h0000_0F00);
        sw(M_USR);
        read_a(4'd3, d);
        check("R5 reg 3 in user mode", d, 32'h1000_0003);
        read_a(4'd15, d);
        check("R5 reg 15 in user mode", d, 32'h0000_0F00);
    endtask

    // R1, R2, R3, R6, R11: per-bank stack, link and status copies.
    task automatic t_banked();
        logic [4:0] ml [6] = '{M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND};
        logic [31:0] d;
        for (int k = 0; k < 6; k++) begin
            int b;
            sw(ml[k]);
            check("R11 mode after switch", {27'd0, cur_mode}, {27'd0, ml[k]});
            b = bank_of(ml[k]);
            exp_sp[b]  = 32'hA000_0000 | (k << 4);
            exp_lr[b]  = 32'hB000_0000 | (k << 4);
            exp_sts[b] = 32'hC000_0000 | (k << 4);
            wr(4'd13, exp_sp[b]);
            wr(4'd14, exp_lr[b]);
            wr_sts(exp_sts[b]);
        end
        for (int k = 5; k >= 0; k--) begin
            int b;
            sw(ml[k]);
            b = bank_of(ml[k]);
            read_a(4'd13, d);
            check($sformatf("R1 R2 reg 13 mode %h", ml[k]), d, exp_sp[b]);
            read_b(4'd14, d);
            check($sformatf("R2 reg 14 mode %h", ml[k]), d, exp_lr[b]);
            check($sformatf("R6 status mode %h", ml[k]), sts_rd_data, exp_sts[b]);
        end
        sw(M_SYS);
        read_a(4'd13, d);
        check("R3 system sees user reg 13", d, exp_sp[0]);
        exp_lr[0] = 32'hB0B0_0000;
        wr(4'd14, exp_lr[0]);
        sw(M_USR);
        read_a(4'd14, d);
        check("R3 user sees system write", d, exp_lr[0]);
    endtask

    // R4: fast copy of registers 8 to 12.
    task automatic t_fiq();
        logic [31:0] d;
        sw(M_USR);
        for (int r = 8; r < 13; r++) wr(4'(r), 32'h8000_0000 + r);
        sw(M_FIQ);
        for (int r = 8; r < 13; r++) begin
            read_a(4'(r), d);
            check($sformatf("R4 fast reg %0d untouched", r), d, 32'd0);
            wr(4'(r), 32'hF000_0000 + r);
        end
        sw(M_ABT);
        for (int r = 8; r < 13; r++) begin
            read_b(4'(r), d);
            check($sformatf("R4 shared reg %0d in abort", r), d, 32'h8000_0000 + r);
        end
        sw(M_FIQ);
        for (int r = 8; r < 13; r++) begin
            read_a(4'(r), d);
            check($sformatf("R4 fast reg %0d restored", r), d, 32'hF000_0000 + r);
        end
        read_a(4'd13, d);
        check("R4 fast reg 13 kept", d, exp_sp[5]);
    endtask

    // R7: switching to the current mode changes nothing.
    task automatic t_same();
        logic [31:0] d;
        sw(M_FIQ);
        check("R7 mode unchanged", {27'd0, cur_mode}, {27'd0, M_FIQ});
        check("R7 no error", {31'd0, mode_err}, 32'd0);
        read_a(4'd10, d);
        check("R7 reg 10 unchanged", d, 32'hF000_000A);
        read_b(4'd13, d);
        check("R7 reg 13 unchanged", d, exp_sp[5]);
        check("R7 status unchanged", sts_rd_data, exp_sts[5]);
    endtask

    // R8: illegal encodings are refused and flagged for one cycle.
    task automatic t_invalid();
        logic [31:0] d;
        logic [4:0] bad [2] = '{5'h05, 5'h1A};
        for (int k = 0; k < 2; k++) begin
            sw(bad[k]);
            check("R8 error raised", {31'd0, mode_err}, 32'd1);
            check("R8 mode held", {27'd0, cur_mode}, {27'd0, M_FIQ});
            read_a(4'd13, d);
            check("R8 reg 13 held", d, exp_sp[5]);
            read_b(4'd8, d);
            check("R8 reg 8 held", d, 32'hF000_0008);
            cyc();
            check("R8 error one cycle", {31'd0, mode_err}, 32'd0);
        end
    endtask

    // R9: write during a switch lands in the outgoing bank.
    task automatic t_write_switch();
        logic [31:0] d;
        sw(M_IRQ);
        wr_en = 1'b1; wr_addr = 4'd13; wr_data = 32'hDEAD_0012;
        sts_wr_en = 1'b1; sts_wr_data = 32'hCAFE_0012;
        mode_req = 1'b1; mode_tgt = M_SVC;
        cyc();
        wr_en = 1'b0; sts_wr_en = 1'b0; mode_req = 1'b0;
        exp_sp[4] = 32'hDEAD_0012;
        exp_sts[4] = 32'hCAFE_0012;
        check("R9 now supervisor", {27'd0, cur_mode}, {27'd0, M_SVC});
        read_a(4'd13, d);
        check("R9 supervisor reg 13 intact", d, exp_sp[1]);
        check("R9 supervisor status intact", sts_rd_data, exp_sts[1]);
        sw(M_IRQ);
        read_a(4'd13, d);
        check("R9 interrupt reg 13 got write", d, exp_sp[4]);
        check("R9 interrupt status got write", sts_rd_data, exp_sts[4]);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; sts_wr_en = 1'b0; mode_req = 1'b0;
        wr_addr = '0; wr_data = '0; sts_wr_data = '0; mode_tgt = M_SVC;
        rd_a_addr = '0; rd_b_addr = '0;
        t_reset();
        t_common();
        t_banked();
        t_fiq();
        t_same();
        t_invalid();
        t_write_switch();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule